// File: doc/BRIEF.md
# DS3 Transmit Payload Serial Input

This block sits between system-side equipment that supplies a serial payload stream and a DS3 transmitter. It runs on the line-rate bit clock and counts through the 4760-bit M-frame with three nested counters: 85-bit blocks, 8 blocks per subframe and 7 subframes per frame. The first bit of every block is an overhead bit. During overhead bits the outgoing bit comes from a separate overhead input. During payload bits it comes from the sampled serial input. Both paths have one bit of pipeline latency.

The system side gets two kinds of timing help. A single output does one of two jobs, chosen by a mode input that is sampled while reset is held. In the first mode it is a warning pulse, one bit period long, that comes in the bit before each overhead bit. In the second mode it is a gapped demand clock. This clock has no edges during overhead bits. The system changes its data on the rising edge of this clock, and the block captures the data on the falling edge. A separate end-of-frame pulse marks the last bit of each frame, which lets the transmitter keep control of frame alignment.

Top module: `ds3tx_payload_in`

## Requirements
- R1: While synchronous active-high reset is held, `serOut`, `ohWarnGap` and `frameEnd` are low. After reset is released, the first bit processed is an overhead bit.
- R2: A frame is 4760 bit periods long. Position 0 is the first bit after reset. A bit is overhead exactly when its position modulo 85 is 0, which gives 56 overhead bits and 4704 payload bits per frame.
- R3: For an overhead position, `serOut` one clock later equals `ohBit` from that position. The value of `serIn` has no effect on it.
- R4: For a payload position, `serOut` one clock later equals `serIn` from that position.
- R5: In warning mode (latched mode 0), `ohWarnGap` is high only during positions whose value modulo 85 is 84, which is the bit period just before each overhead bit. At every other position it is low.
- R6: `frameEnd` is high only during position 4759, for one bit period per frame.
- R7: In gapped mode (latched mode 1), `ohWarnGap` is high during the second half (clock low) of every payload bit period. It stays low through the whole of every overhead bit period.
- R8: In gapped mode, the falling edge of `ohWarnGap` coincides with the clock edge that captures `serIn`. Data driven after the rising edge of `ohWarnGap` is the data that gets sent.
- R9: `gapMode` is latched only while reset is held. Changing it outside reset has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate bit clock |
| rst | input | 1 | Synchronous active-high reset |
| gapMode | input | 1 | Mode select (1 = gapped demand clock), latched during reset |
| serIn | input | 1 | Serial payload bit from the system side |
| ohBit | input | 1 | Overhead bit value for the current position |
| serOut | output | 1 | Merged outgoing bit, one clock of latency |
| ohWarnGap | output | 1 | Overhead warning pulse or gapped demand clock |
| frameEnd | output | 1 | High during the last bit of each frame |

## Verification
The last frame bit, position 4759, is also the bit just before the next frame's first overhead bit. In warning mode, `frameEnd` and the overhead warning must therefore be high in the same cycle. The bench runs the counter through full frames so that every frame boundary produces this overlap, and it compares both outputs at each bit against position functions computed in the bench. In gapped mode the same boundary must show the end-of-frame pulse together with a final demand-clock pulse, followed by a quiet overhead bit. The bench also counts the demand-clock rising edges over exactly one frame.

// File: rtl/ds3tx_pkg.sv
package ds3tx_pkg;
  // Strobes passed from the frame position control to the datapath
  typedef struct packed {
    logic isOh;     // current bit is an overhead position
    logic preOh;    // current bit is the last of a block
    logic lastBit;  // current bit closes the M-frame
  } txStrobe_t;
endpackage

// File: rtl/ds3tx_ctrl.sv
module ds3tx_ctrl #(
  parameter int BLOCK_BITS     = 85,
  parameter int BLOCKS_PER_SUB = 8,
  parameter int SUBFRAMES      = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  output ds3tx_pkg::txStrobe_t strobe
);
  localparam int BIT_W = $clog2(BLOCK_BITS + 1);
  localparam int BLK_W = $clog2(BLOCKS_PER_SUB + 1);
  localparam int SUB_W = $clog2(SUBFRAMES + 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BLOCK_BITS - 1);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLOCKS_PER_SUB - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUBFRAMES - 1);

  logic [BIT_W-1:0] bitCnt;
  logic [BLK_W-1:0] blkCnt;
  logic [SUB_W-1:0] subCnt;
  logic bitWrap, blkWrap, subWrap;

  assign bitWrap = (bitCnt == BIT_LAST);
  assign blkWrap = (blkCnt == BLK_LAST);
  assign subWrap = (subCnt == SUB_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt <= '0;
      blkCnt <= '0;
      subCnt <= '0;
    end else begin
      bitCnt <= bitWrap ? '0 : bitCnt + 1'b1;
      if (bitWrap) begin
        blkCnt <= blkWrap ? '0 : blkCnt + 1'b1;
        if (blkWrap) subCnt <= subWrap ? '0 : subCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.isOh    = (bitCnt == '0);
    strobe.preOh   = bitWrap;
    strobe.lastBit = bitWrap && blkWrap && subWrap;
  end
endmodule

// File: rtl/ds3tx_dpath.sv
module ds3tx_dpath (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 gapMode,
  input  logic                 serIn,
  input  logic                 ohBit,
  input  ds3tx_pkg::txStrobe_t strobe,
  output logic                 modeQ,
  output logic                 serOut,
  output logic                 ohWarnGap,
  output logic                 frameEnd
);
  logic payEn;
  logic gapClk;
  logic warnPulse;

  // Mode is captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) modeQ <= gapMode;
  end

  // Merge overhead and payload with one bit of latency
  always_ff @(posedge clk) begin
    if (rst) serOut <= 1'b0;
    else     serOut <= strobe.isOh ? ohBit : serIn;
  end

  // Enable changes only at the rising clock edge, when ~clk is already low,
  // so the gated copy cannot glitch. It falls at the capture edge.
  assign payEn     = modeQ && !strobe.isOh;
  assign gapClk    = ~clk & payEn;
  assign warnPulse = !modeQ && strobe.preOh;
  assign ohWarnGap = modeQ ? gapClk : warnPulse;
  assign frameEnd  = strobe.lastBit;
endmodule

// File: rtl/ds3tx_payload_in.sv
module ds3tx_payload_in #(
  parameter int BLOCK_BITS     = 85,
  parameter int BLOCKS_PER_SUB = 8,
  parameter int SUBFRAMES      = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic gapMode,
  input  logic serIn,
  input  logic ohBit,
  output logic serOut,
  output logic ohWarnGap,
  output logic frameEnd
);
  ds3tx_pkg::txStrobe_t strobe;
  logic modeQ;

  ds3tx_ctrl #(
    .BLOCK_BITS(BLOCK_BITS),
    .BLOCKS_PER_SUB(BLOCKS_PER_SUB),
    .SUBFRAMES(SUBFRAMES)
  ) u_ctrl (
    .clk(clk),
    .rst(rst),
    .strobe(strobe)
  );

  ds3tx_dpath u_dpath (
    .clk(clk),
    .rst(rst),
    .gapMode(gapMode),
    .serIn(serIn),
    .ohBit(ohBit),
    .strobe(strobe),
    .modeQ(modeQ),
    .serOut(serOut),
    .ohWarnGap(ohWarnGap),
    .frameEnd(frameEnd)
  );
endmodule

// File: rtl/ds3tx_payload_in_chk.sv
module ds3tx_payload_in_chk (
  input logic                 clk,
  input logic                 rst,
  input logic                 serIn,
  input logic                 ohBit,
  input logic                 serOut,
  input logic                 ohWarnGap,
  input logic                 frameEnd,
  input logic                 modeQ,
  input ds3tx_pkg::txStrobe_t strobe
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!frameEnd && !ohWarnGap && strobe.isOh));

  assert_frame_restart_R2: assert property (@(posedge clk) disable iff (rst)
    frameEnd |=> strobe.isOh);

  assert_oh_merge_R3: assert property (@(posedge clk) disable iff (rst)
    strobe.isOh |=> (serOut == $past(ohBit)));

  assert_pay_merge_R4: assert property (@(posedge clk) disable iff (rst)
    !strobe.isOh |=> (serOut == $past(serIn)));

  assert_warn_single_R5: assert property (@(posedge clk) disable iff (rst)
    (!modeQ && ohWarnGap) |=> !ohWarnGap);

  assert_end_with_warn_R5: assert property (@(posedge clk) disable iff (rst)
    (frameEnd && !modeQ) |-> ohWarnGap);

  assert_end_single_R6: assert property (@(posedge clk) disable iff (rst)
    frameEnd |=> !frameEnd);

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(modeQ));
endmodule

bind ds3tx_payload_in ds3tx_payload_in_chk u_chk (
  .clk(clk),
  .rst(rst),
  .serIn(serIn),
  .ohBit(ohBit),
  .serOut(serOut),
  .ohWarnGap(ohWarnGap),
  .frameEnd(frameEnd),
  .modeQ(modeQ),
  .strobe(strobe)
);

// File: tb/ds3tx_payload_in_tb.sv
module ds3tx_payload_in_tb;
  localparam int FRAME = 4760;
  localparam int BLK   = 85;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gapMode = 1'b0;
  logic serIn = 1'b0;
  logic ohBit = 1'b0;
  wire  serOut, ohWarnGap, frameEnd;

  always #2 clk = ~clk;  // 250 MHz

  ds3tx_payload_in u_dut (
    .clk(clk), .rst(rst), .gapMode(gapMode), .serIn(serIn), .ohBit(ohBit),
    .serOut(serOut), .ohWarnGap(ohWarnGap), .frameEnd(frameEnd)
  );

  int checks = 0;
  int fails = 0;
  int pos = 0;
  int prevPos = 0;
  bit mode = 1'b0;
  bit prevValid = 1'b0;
  bit prevExp = 1'b0;
  bit countEdges = 1'b0;
  int gapEdges = 0;
  bit done = 1'b0;

  always @(posedge ohWarnGap) if (countEdges) gapEdges++;

  function automatic bit expOh(int p);   return (p % BLK) == 0; endfunction
  function automatic bit expWarn(int p); return (p % BLK) == BLK - 1; endfunction
  function automatic bit expEnd(int p);  return p == FRAME - 1; endfunction
  function automatic bit expGap(int p);  return (p % BLK) != 0; endfunction

  task automatic check(input bit act, input bit exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at pos %0d: actual %0b expected %0b", tag, what, pos, act, exp);
    end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Hold reset with the given mode, check quiet outputs, release
  task automatic doReset(input bit m, input int cyc);
    gapMode = m;
    rst = 1'b1;
    repeat (cyc) @(negedge clk);
    #1;
    check(serOut, 1'b0, "R1", "serOut in reset");
    check(ohWarnGap, 1'b0, "R1", "ohWarnGap in reset");
    check(frameEnd, 1'b0, "R1", "frameEnd in reset");
    rst = 1'b0;
    pos = 0;
    mode = m;
    prevValid = 1'b0;
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) begin
      if (prevValid)
        check(serOut, prevExp, expOh(prevPos) ? "R3" : "R4", "serOut");
      if (mode) check(ohWarnGap, expGap(pos), "R7", "gapped clock high phase");
      else      check(ohWarnGap, expWarn(pos), "R5", "overhead warning");
      check(frameEnd, expEnd(pos), "R6", "frameEnd");
      ohBit = 1'($urandom);
      // R3: on overhead bits drive the opposite of ohBit to prove serIn is ignored
      serIn = expOh(pos) ? ~ohBit : 1'($urandom);
      prevExp = expOh(pos) ? ohBit : serIn;
      prevPos = pos;
      prevValid = 1'b1;
      @(posedge clk);
      #1;
      if (mode) check(ohWarnGap, 1'b0, "R8", "gapped clock low after capture edge");
      @(negedge clk);
      #1;
      pos = (pos + 1) % FRAME;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    doReset(1'b0, 3);
    runCycles(FRAME);
    gapMode = 1'b1;                // R9: change outside reset, must be ignored
    runCycles(FRAME + 10);
    doReset(1'b1, 2);
    gapEdges = 0;
    countEdges = 1'b1;
    runCycles(FRAME);
    countEdges = 1'b0;
    check(gapEdges == 4704, 1'b1, "R2", "demand clock edges per frame");
    gapMode = 1'b0;                // R9: gapped mode must persist
    runCycles(300);
    runCycles($urandom_range(500, 50));
    doReset(1'b0, 1);              // mid-frame reset restarts at overhead (R1)
    runCycles(200);
    finishRun();
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      finishRun();
    end
  end
endmodule